// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is an on-chip synchronous static memory with a built-in two-bit burst sequencer. Every control and address input is sampled on the rising clock edge. An access starts on one of two address strobes: the processor strobe or the controller strobe. The start address is then latched, and its two lowest bits seed a burst counter. On later cycles the advance input steps that counter. The step is linear and wraps inside the aligned group of four words, while the upper address bits stay put. A read returns its word through a registered output one clock after the address is sampled.

Writes go through a global-write input or through a byte-write enable with one active-low select per byte lane. Global write overrides the byte path. Three chip enables of mixed polarity decide whether a strobe selects the device or deselects it. The output-enable input gates the data-valid indication without any clock. On the first read beat after a deselected period, the output stays disabled whatever output enable does. The data bus is split into separate in, out and drive-enable signals, so the pads can sit outside the block.

Top module: `burst_sram`

## Requirements
- R1: A strobe sampled while the device is selected (ce1_n=0, ce2=1, ce3_n=0) starts an access at `addr`. A read places the addressed word on `dout` one clock later, and `dout_en` is then 1 when `oe_n` is 0.
- R2: A strobe sampled while any chip enable is inactive deselects the device. No read or write happens on that cycle, or on any later cycle without a strobe, until a selecting strobe arrives.
- R3: `adsp_n`=0 has no effect while `ce1_n`=1. Such a cycle behaves exactly as a cycle with no strobe, so a running burst continues.
- R4: A cycle started by `adsp_n`=0 with `ce1_n`=0 is always a read. `gw_n`, `bwe_n` and `bsel_n` on that cycle write nothing. If `adsp_n` and `adsc_n` are both 0, the processor strobe governs.
- R5: The counter loads `addr[1:0]` at the start. Each later cycle with `adv_n`=0 advances the low two bits by one modulo 4 (for example 2,3,0,1). The bits above them keep their captured value.
- R6: A cycle without a strobe and with `adv_n`=1 accesses the same word as the previous cycle.
- R7: `gw_n`=0 on a write-capable cycle writes all byte lanes from `din`, whatever the values of `bwe_n` and `bsel_n`.
- R8: With `gw_n`=1 and `bwe_n`=0, the cycle writes lane i (bits 8i+7..8i) only where `bsel_n[i]`=0. With both `gw_n` and `bwe_n` at 1, or with no lane selected, the cycle is a read.
- R9: `dout_en` is 0 whenever `oe_n` is 1. A change on `oe_n` reaches `dout_en` without waiting for a clock edge.
- R10: The first read beat of an access that starts from the deselected state (including after reset) leaves `dout_en` at 0, even with `oe_n`=0. Later beats of that access follow R1.
- R11: While and right after `rst` is 1, the device is deselected and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address sampled on a strobe |
| adsp_n | input | 1 | Processor address strobe, active low, needs ce1_n=0 |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| dout_en | output | 1 | Drive enable for the external data pads |

## Verification
The bench uses the default build: 8 address bits, 32 data bits and four byte lanes. That gives 256 words, few enough to fill every word with known data first, so the reference array has a defined value at each address that a random burst can reach. Directed bursts cover the wrap from 3 to 0 inside a group. A long random phase mixes both strobes, each chip-enable polarity, partial byte masks and output-enable toggles against the behavioural model.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

endpackage

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bsel_n,
  output sram_op_e          op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  lane_we,
  output logic              fresh
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q;
  logic [1:0]      cnt_q;
  logic            active_q;

  logic       p_start, start, sel, cont, live, wr_req;
  logic [1:0] nxt_cnt;
  logic [LANES-1:0] mask;

  always_comb begin
    p_start = !adsp_n && !ce1_n;
    start   = p_start || !adsc_n;
    sel     = !ce1_n && ce2 && !ce3_n;
    cont    = !start && active_q;
    nxt_cnt = (cont && !adv_n) ? cnt_q + 2'd1 : cnt_q;
    cur_addr = start ? addr : {base_q, nxt_cnt};
    live    = (start && sel) || cont;
    if (!gw_n)       mask = '1;
    else if (!bwe_n) mask = ~bsel_n;
    else             mask = '0;
    wr_req  = |mask;
    if (!live)                    op = OP_IDLE;
    else if (wr_req && !p_start)  op = OP_WRITE;
    else                          op = OP_READ;
    lane_we = (op == OP_WRITE) ? mask : '0;
    fresh   = start && sel && !active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= sel;
      if (sel) begin
        base_q <= addr[ADDR_W-1:2];
        cnt_q  <= addr[1:0];
      end
    end else if (cont) begin
      cnt_q <= nxt_cnt;
    end
  end

  // R2: after a deselecting strobe, nothing happens until the next strobe
  a_r2_desel_idle: assert property (@(posedge clk) disable iff (rst)
    (start && !sel) |=> (start || op == OP_IDLE));

  // R5: an advancing beat steps the low bits by one and keeps the high bits
  a_r5_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!start && active_q && !adv_n) |->
      (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)) &&
      (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  // R6: a non-advancing beat repeats the previous word
  a_r6_hold_addr: assert property (@(posedge clk) disable iff (rst)
    (!start && active_q && adv_n) |-> (cur_addr == $past(cur_addr)));

endmodule

// File: rtl/burst_byte_ram.sv
module burst_byte_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  we,
  input  logic              re,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  localparam int LW    = DATA_W / LANES;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] cells [DEPTH];
    logic [LW-1:0] q;
    always_ff @(posedge clk) begin
      if (we[g]) cells[addr] <= wd[g*LW +: LW];
      if (re)    q <= cells[addr];
    end
    assign rd[g*LW +: LW] = q;
  end

endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic rd_go,
  input  logic fresh,
  input  logic oe_n,
  output logic dout_en
);
  logic vld_q, fresh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      vld_q   <= rd_go;
      fresh_q <= rd_go && fresh;
    end
  end

  assign dout_en = !oe_n && vld_q && !fresh_q;

  // R11: the cycle after reset never drives the bus
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !dout_en);

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  sram_op_e          op;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lane_we;
  logic              fresh;
  logic              rd_go;

  burst_addr_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .op(op), .cur_addr(cur_addr),
    .lane_we(lane_we), .fresh(fresh)
  );

  assign rd_go = (op == OP_READ);

  burst_byte_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_ram (
    .clk(clk), .addr(cur_addr), .we(lane_we), .re(rd_go), .wd(din), .rd(dout)
  );

  burst_out_stage u_out (
    .clk(clk), .rst(rst), .rd_go(rd_go), .fresh(fresh), .oe_n(oe_n),
    .dout_en(dout_en)
  );

  // R4: a processor-strobe cycle never reaches the write port
  a_r4_adsp_reads: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && !ce1_n) |-> (lane_we == '0));

  // R10: first beat out of deselect keeps the bus released
  a_r10_first_masked: assert property (@(posedge clk) disable iff (rst)
    (rd_go && fresh) |=> !dout_en);

  // R1: a later read beat becomes visible under output enable
  a_r1_beat_visible: assert property (@(posedge clk) disable iff (rst)
    (rd_go && !fresh) |=> (dout_en == !oe_n));

endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NL = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [NL-1:0] bsel_n = '1;
  logic oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL)) uut (
    .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .din(din), .dout(dout),
    .dout_en(dout_en)
  );

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  bit m_act = 0;
  int m_base = 0, m_cnt = 0;
  bit pend_rd = 0, pend_fresh = 0;
  logic [DW-1:0] pend_data = '0;

  task automatic check_bit(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dout_en=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_word(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dout=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model of one clock, evaluated on the inputs set for it
  task automatic model_edge();
    bit pstart, start, sel, live, fr, wr;
    int a;
    pstart = !adsp_n && !ce1_n;
    start  = pstart || !adsc_n;
    sel    = !ce1_n && ce2 && !ce3_n;
    live = 0; fr = 0; a = 0;
    if (rst) begin
      m_act = 0;
    end else if (start) begin
      if (sel) begin
        live = 1; fr = !m_act; a = int'(addr);
        m_base = a / 4; m_cnt = a % 4; m_act = 1;
      end else m_act = 0;
    end else if (m_act) begin
      if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      a = m_base * 4 + m_cnt; live = 1;
    end
    wr = live && !pstart && (!gw_n || (!bwe_n && bsel_n != '1));
    pend_rd = live && !wr;
    pend_fresh = fr;
    pend_data = ref_mem[a];
    if (wr)
      for (int i = 0; i < NL; i++)
        if (!gw_n || !bsel_n[i]) ref_mem[a][i*8 +: 8] = din[i*8 +: 8];
  endtask

  // Inputs are set at a falling edge; model, clock, then compare after the edge
  task automatic tick(string tag);
    bit exp_en;
    model_edge();
    @(posedge clk);
    #1;
    exp_en = !oe_n && pend_rd && !pend_fresh && !rst;
    check_bit(tag, dout_en, exp_en);
    if (exp_en) check_word(tag, dout, pend_data);
    @(negedge clk);
  endtask

  task automatic quiet();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = '1;
    ce1_n = 0; ce2 = 1; ce3_n = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick("R11 in reset");
    tick("R11 in reset");
    rst = 0;
    tick("R11 after reset");

    // R7: fill every word with a global write, byte controls set to disable
    for (int i = 0; i < DEPTH; i++) begin
      quiet(); adsc_n = 0; addr = AW'(i); gw_n = 0; bwe_n = 1; bsel_n = '1;
      din = {8'(i), 8'(i ^ 8'h5a), 8'(~i), 8'(i + 3)};
      tick("R7 global fill");
    end
    quiet();

    // R1: single processor-strobe read
    adsp_n = 0; addr = 8'h05; tick("R1 read issue");
    quiet(); adsc_n = 0; ce2 = 0; tick("R1 data beat / R2 deselect");
    quiet();

    // R10: fresh access from deselected state, burst R5 wrap 2,3,0,1
    adsp_n = 0; addr = 8'h16; tick("R10 fresh start");
    quiet(); adv_n = 0; tick("R10 first beat masked / R5");
    tick("R5 wrap to 0"); tick("R5 beat 1");
    adv_n = 1; tick("R6 hold"); tick("R6 hold again");

    // R3: processor strobe with ce1_n high does not restart
    adsp_n = 0; ce1_n = 1; adv_n = 0; addr = 8'hA0; tick("R3 ignored strobe");
    quiet(); tick("R3 burst continued");

    // R2: each enable polarity deselects
    adsc_n = 0; ce1_n = 1; tick("R2 ce1_n high");
    quiet(); adv_n = 0; tick("R2 idle after deselect"); tick("R2 idle");
    quiet(); adsc_n = 0; addr = 8'h30; tick("R2 reselect");
    quiet(); adsc_n = 0; ce3_n = 1; tick("R2 ce3_n high");
    quiet(); adv_n = 0; tick("R2 idle ce3"); tick("R2 idle ce3");

    // R4: processor strobe with write controls is a read
    quiet(); adsp_n = 0; adsc_n = 0; addr = 8'h40; gw_n = 0; din = 32'hDEADBEEF;
    tick("R4 no write");
    quiet(); tick("R4 read beat");
    adsc_n = 0; addr = 8'h40; tick("R4 memory kept");
    quiet(); tick("R4 memory kept beat");

    // R8: byte writes over a burst, then read back
    adsc_n = 0; addr = 8'h52; bwe_n = 0; bsel_n = 4'b1010; din = 32'h11223344;
    tick("R8 lanes 0,2");
    adsc_n = 1; adv_n = 0; bsel_n = 4'b0111; din = 32'hA5A5A5A5; tick("R8 lane 3");
    bwe_n = 1; tick("R8 bwe_n high reads");
    bwe_n = 0; bsel_n = '1; tick("R8 no lane reads");
    quiet(); adsc_n = 0; addr = 8'h50; tick("R8 readback");
    quiet(); adv_n = 0; tick("R8 readback"); tick("R8 readback"); tick("R8 readback");

    // R9: output enable acts without a clock
    quiet(); oe_n = 1; adsc_n = 0; addr = 8'h77; tick("R9 issue");
    quiet(); tick("R9 oe_n high");
    oe_n = 0; #1;
    check_bit("R9 async enable", dout_en, pend_rd && !pend_fresh);
    oe_n = 1; #1;
    check_bit("R9 async disable", dout_en, 1'b0);
    oe_n = 0;
    @(negedge clk);

    // Random mix against the model
    for (int n = 0; n < 4000; n++) begin
      adsp_n = ($urandom_range(0, 4) != 0);
      adsc_n = ($urandom_range(0, 5) != 0);
      adv_n  = ($urandom_range(0, 2) == 0);
      ce1_n  = ($urandom_range(0, 7) == 0);
      ce2    = ($urandom_range(0, 7) != 0);
      ce3_n  = ($urandom_range(0, 7) == 0);
      gw_n   = ($urandom_range(0, 5) != 0);
      bwe_n  = ($urandom_range(0, 2) != 0);
      bsel_n = NL'($urandom);
      oe_n   = ($urandom_range(0, 5) == 0);
      addr   = AW'($urandom);
      din    = $urandom;
      tick("R1 R5 R8 random mix");
    end

    finish_run();
  end

endmodule